// File: doc/BRIEF.md
# AXI4 Write Burst Master Engine

This block turns queued write requests into AXI4 write bursts. Two first-word-fall-through queues feed it. The first holds burst requests, each a byte address and a length code. The second holds data beats, each a data word and its byte strobes. The block shows each request on the write-address channel and each beat on the write-data channel. It ends every burst with a last-beat flag, accepts every write response, and raises a sticky flag when a response reports an error. The queues may live in another clock domain. The block sees only their read side: head contents, an empty flag and a pop strobe. All of its own logic runs on the single bus clock.

Address issue does not wait for data. Up to 16 bursts may have their address taken from the request queue before all of their beats have been loaded. The block keeps the length code of each such burst in an internal 16-entry queue. The data side reads that queue to know which beat of the current burst carries the last-beat flag. When the length queue is full, no further address is issued. No request or beat is consumed until the init-done input is high.

Top module: `axi_wburst_master`

## Requirements
- R1: Each address phase carries the 32-bit address and 8-bit length code of its request exactly as queued, and requests are issued in queue order. The length code equals the number of beats minus one.
- R2: The write-address attributes are constant: size 3'b011 (8 bytes), burst 2'b01 (incrementing), cache 4'b0011, lock 0, protection 3'b000, QoS 4'b0000, ID 0 and user 0. The write-data user bit is 0. Every response seen has ID 0 and user 0.
- R3: Once the address valid is high without ready, it stays high and its address and length stay unchanged until ready is sampled high.
- R4: Once the data valid is high without ready, it stays high and its data, strobes and last flag stay unchanged until ready is sampled high.
- R5: Data beats are issued in data-queue order with their data and strobes unchanged. The last-beat flag is high on beat (length code + 1) of each burst, taking bursts in address order, and low on every other beat.
- R6: Addresses are issued while the data queue is empty; address issue does not wait for data.
- R7: At most 16 bursts may have their address issued before their final beat has been loaded. With no data available, exactly 16 address handshakes occur and the address valid then stays low.
- R8: While init-done is low, neither queue is popped and neither the address valid nor the data valid rises.
- R9: The response ready output is high in every cycle after reset.
- R10: The error flag sets after a response handshake with code 2'b10 or 2'b11. It stays set until ARESETN is driven low. Codes 2'b00 and 2'b01 leave it unchanged.
- R11: After a synchronous active-low reset, the address valid, the data valid and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Enables traffic when high |
| rq_addr | input | 32 | Head request byte address |
| rq_len | input | 8 | Head request length code (beats minus one) |
| rq_empty | input | 1 | Request queue empty |
| rq_pop | output | 1 | Consumes the head request |
| dq_data | input | 64 | Head beat data |
| dq_strb | input | 8 | Head beat byte strobes |
| dq_empty | input | 1 | Data queue empty |
| dq_pop | output | 1 | Consumes the head beat |
| m_awid | output | 1 | Write address ID |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Burst length code |
| m_awsize | output | 3 | Beat size |
| m_awburst | output | 2 | Burst type |
| m_awlock | output | 1 | Lock |
| m_awcache | output | 4 | Cache attributes |
| m_awprot | output | 3 | Protection |
| m_awqos | output | 4 | Quality of service |
| m_awuser | output | 1 | Address user bit |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_wuser | output | 1 | Data user bit |
| m_wvalid | output | 1 | Data valid |
| m_wready | input | 1 | Data ready |
| m_bid | input | 1 | Response ID |
| m_bresp | input | 2 | Response code |
| m_buser | input | 1 | Response user bit |
| m_bvalid | input | 1 | Response valid |
| m_bready | output | 1 | Response ready |
| wr_err | output | 1 | Sticky error-response flag |

## Verification
A single two-beat burst is first queued while init-done is low. It shows whether anything leaks before enable, and then whether the address, attributes and beat framing are right once traffic is allowed. Bursts of one, four and eight beats run against pseudo-random ready stalls on both channels, which shows whether valid and payload hold under back-pressure and whether the last flag follows each burst's own length. Twenty address requests with no data separate decoupled address issue from the outstanding limit: exactly sixteen must pass, and the other four follow once data arrives. A sequence of response codes, including an OKAY after an error and a reset, tells the sticky error behaviour apart from a flag that merely follows the last response.

// File: rtl/axwm_pkg.sv
// Shared constants for the write burst master.
// Assumes a 64-bit data bus and full-width incrementing bursts only.
package axwm_pkg;
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = 8;
    localparam int DATA_W      = 64;
    localparam int STRB_W      = DATA_W / 8;
    localparam int OUTSTANDING = 16;

    localparam logic [2:0] SIZE_8B     = 3'b011;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [3:0] CACHE_BUFMD = 4'b0011;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;
endpackage

// File: rtl/axwm_len_fifo.sv
// Length-code queue: one entry per burst whose address was issued but
// whose final beat is not yet loaded. The head is read combinationally.
// Assumes the caller never pushes when full or pops when empty.
module axwm_len_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_len,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_len;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    AST_LQ_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R7
    AST_LQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R5
endmodule

// File: rtl/axwm_aw_issue.sv
// Address issue stage: takes a request from the request queue into the
// address register whenever the register is free or being accepted,
// records its length code, and holds the payload until ready.
// Assumes first-word-fall-through request queue.
module axwm_aw_issue #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic [ADDR_W-1:0] rq_addr,
    input  logic [LEN_W-1:0]  rq_len,
    input  logic              rq_empty,
    output logic              rq_pop,
    input  logic              lq_full,
    output logic              lq_push,
    output logic [LEN_W-1:0]  lq_len,
    output logic              awvalid,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    input  logic              awready
);
    logic load;

    // Load when enabled, a request waits, the register frees, and room remains.
    always_comb begin
        load = init_done && !rq_empty && !lq_full && (!awvalid || awready);
    end

    assign rq_pop  = load;
    assign lq_push = load;
    assign lq_len  = rq_len;

    // Address register with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awvalid <= 1'b0;
            awaddr  <= '0;
            awlen   <= '0;
        end else if (load) begin
            awvalid <= 1'b1;
            awaddr  <= rq_addr;
            awlen   <= rq_len;
        end else if (awready) begin
            awvalid <= 1'b0;
        end
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));  // R3
    AST_AW_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !awvalid) |=> !awvalid);  // R8
endmodule

// File: rtl/axwm_w_issue.sv
// Data issue stage: moves beats from the data queue into the data register,
// counts beats against the head length code and flags the final beat,
// then retires that length entry. Assumes first-word-fall-through queue.
module axwm_w_issue #(
    parameter int DATA_W = 64,
    parameter int STRB_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic [DATA_W-1:0] dq_data,
    input  logic [STRB_W-1:0] dq_strb,
    input  logic              dq_empty,
    output logic              dq_pop,
    input  logic              lq_empty,
    input  logic [LEN_W-1:0]  lq_head,
    output logic              lq_pop,
    output logic              wvalid,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    input  logic              wready
);
    logic             load;
    logic             final_beat;
    logic [LEN_W-1:0] beat_cnt;

    // Load only when a burst is known, a beat waits and the register frees.
    always_comb begin
        load       = init_done && !dq_empty && !lq_empty && (!wvalid || wready);
        final_beat = (beat_cnt == lq_head);
    end

    assign dq_pop = load;
    assign lq_pop = load && final_beat;

    // Beat position within the burst at the head of the length queue.
    always_ff @(posedge clk) begin
        if (!rst_n)    beat_cnt <= '0;
        else if (load) beat_cnt <= final_beat ? '0 : beat_cnt + 1'b1;
    end

    // Data register with valid and last flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wvalid <= 1'b0;
            wdata  <= '0;
            wstrb  <= '0;
            wlast  <= 1'b0;
        end else if (load) begin
            wvalid <= 1'b1;
            wdata  <= dq_data;
            wstrb  <= dq_strb;
            wlast  <= final_beat;
        end else if (wready) begin
            wvalid <= 1'b0;
        end
    end

    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast)));  // R4
    AST_W_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !wvalid) |=> !wvalid);  // R8
endmodule

// File: rtl/axi_wburst_master.sv
// Write burst master top: joins the address and data issue stages through
// the length queue, ties the constant attributes, and watches responses.
// Assumes one ID, full-width INCR bursts and queues on the bus clock side.
module axi_wburst_master
    import axwm_pkg::*;
#(
    parameter int AW_BITS = ADDR_W,
    parameter int LW_BITS = LEN_W,
    parameter int DW_BITS = DATA_W,
    parameter int MAX_OUT = OUTSTANDING
) (
    input  logic                 aclk,
    input  logic                 aresetn,
    input  logic                 init_done,
    input  logic [AW_BITS-1:0]   rq_addr,
    input  logic [LW_BITS-1:0]   rq_len,
    input  logic                 rq_empty,
    output logic                 rq_pop,
    input  logic [DW_BITS-1:0]   dq_data,
    input  logic [DW_BITS/8-1:0] dq_strb,
    input  logic                 dq_empty,
    output logic                 dq_pop,
    output logic                 m_awid,
    output logic [AW_BITS-1:0]   m_awaddr,
    output logic [LW_BITS-1:0]   m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awlock,
    output logic [3:0]           m_awcache,
    output logic [2:0]           m_awprot,
    output logic [3:0]           m_awqos,
    output logic                 m_awuser,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [DW_BITS-1:0]   m_wdata,
    output logic [DW_BITS/8-1:0] m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wuser,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic                 m_bid,
    input  logic [1:0]           m_bresp,
    input  logic                 m_buser,
    input  logic                 m_bvalid,
    output logic                 m_bready,
    output logic                 wr_err
);
    localparam int SW_BITS = DW_BITS / 8;

    logic               lq_push, lq_pop, lq_full, lq_empty;
    logic [LW_BITS-1:0] lq_len, lq_head;

    assign m_awid    = 1'b0;
    assign m_awsize  = SIZE_8B;
    assign m_awburst = BURST_INCR;
    assign m_awlock  = 1'b0;
    assign m_awcache = CACHE_BUFMD;
    assign m_awprot  = 3'b000;
    assign m_awqos   = 4'b0000;
    assign m_awuser  = 1'b0;
    assign m_wuser   = 1'b0;
    assign m_bready  = 1'b1;

    axwm_aw_issue #(.ADDR_W(AW_BITS), .LEN_W(LW_BITS)) u_aw (
        .clk(aclk), .rst_n(aresetn), .init_done(init_done),
        .rq_addr(rq_addr), .rq_len(rq_len), .rq_empty(rq_empty), .rq_pop(rq_pop),
        .lq_full(lq_full), .lq_push(lq_push), .lq_len(lq_len),
        .awvalid(m_awvalid), .awaddr(m_awaddr), .awlen(m_awlen), .awready(m_awready)
    );

    axwm_len_fifo #(.WIDTH(LW_BITS), .DEPTH(MAX_OUT)) u_lq (
        .clk(aclk), .rst_n(aresetn), .push(lq_push), .push_len(lq_len),
        .pop(lq_pop), .head(lq_head), .full(lq_full), .empty(lq_empty)
    );

    axwm_w_issue #(.DATA_W(DW_BITS), .STRB_W(SW_BITS), .LEN_W(LW_BITS)) u_w (
        .clk(aclk), .rst_n(aresetn), .init_done(init_done),
        .dq_data(dq_data), .dq_strb(dq_strb), .dq_empty(dq_empty), .dq_pop(dq_pop),
        .lq_empty(lq_empty), .lq_head(lq_head), .lq_pop(lq_pop),
        .wvalid(m_wvalid), .wdata(m_wdata), .wstrb(m_wstrb), .wlast(m_wlast),
        .wready(m_wready)
    );

    // Sticky error flag on any error-coded response handshake.
    always_ff @(posedge aclk) begin
        if (!aresetn)
            wr_err <= 1'b0;
        else if (m_bvalid && m_bready &&
                 (m_bresp == RESP_SLVERR || m_bresp == RESP_DECERR))
            wr_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge aclk) disable iff (!aresetn)
        wr_err |=> wr_err);  // R10
    AST_BRESP_ID: assert property (@(posedge aclk) disable iff (!aresetn)
        m_bvalid |-> (m_bid == 1'b0 && m_buser == 1'b0));  // R2
endmodule

// File: tb/sim_axi_wburst_master.sv
`timescale 1ns/1ps
module sim_axi_wburst_master;
    localparam int QN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    always #4 clk = ~clk;

    // Request and data queue models (first-word-fall-through)
    logic [31:0] aq_addr [QN];
    logic [7:0]  aq_len  [QN];
    logic [63:0] dq_d    [QN];
    logic [7:0]  dq_s    [QN];
    logic        ex_last [QN];
    int at = 0, ah = 0, dt = 0, dh = 0;

    logic        rq_pop, dq_pop;
    logic        awid, awlock, awuser, awvalid, wlast, wuser, wvalid, bready, wr_err;
    logic [31:0] awaddr;
    logic [7:0]  awlen, wstrb;
    logic [2:0]  awsize, awprot;
    logic [1:0]  awburst;
    logic [3:0]  awcache, awqos;
    logic [63:0] wdata;
    logic        aw_allow = 1'b1, w_allow = 1'b1, stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        bvalid = 1'b0;
    logic [1:0]  bresp = 2'b00;

    wire awready = aw_allow && (!stall_en || lfsr[0]);
    wire wready  = w_allow  && (!stall_en || lfsr[3]);

    axi_wburst_master u0 (
        .aclk(clk), .aresetn(rst_n), .init_done(init_done),
        .rq_addr(aq_addr[ah[7:0]]), .rq_len(aq_len[ah[7:0]]), .rq_empty(ah == at), .rq_pop(rq_pop),
        .dq_data(dq_d[dh[7:0]]), .dq_strb(dq_s[dh[7:0]]), .dq_empty(dh == dt), .dq_pop(dq_pop),
        .m_awid(awid), .m_awaddr(awaddr), .m_awlen(awlen), .m_awsize(awsize),
        .m_awburst(awburst), .m_awlock(awlock), .m_awcache(awcache), .m_awprot(awprot),
        .m_awqos(awqos), .m_awuser(awuser), .m_awvalid(awvalid), .m_awready(awready),
        .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_wuser(wuser),
        .m_wvalid(wvalid), .m_wready(wready),
        .m_bid(1'b0), .m_bresp(bresp), .m_buser(1'b0), .m_bvalid(bvalid),
        .m_bready(bready), .wr_err(wr_err)
    );

    // Monitor logs and protocol observers
    logic [31:0] aw_log_a [QN];
    logic [7:0]  aw_log_l [QN];
    logic [63:0] w_log_d  [QN];
    logic [7:0]  w_log_s  [QN];
    logic        w_log_l  [QN];
    int aw_n = 0, w_n = 0, attr_bad = 0, hold_bad_aw = 0, hold_bad_w = 0;
    logic        p_aw_wait = 1'b0, p_w_wait = 1'b0;
    logic [31:0] p_awaddr;
    logic [7:0]  p_awlen;
    logic [63:0] p_wdata;
    logic [7:0]  p_wstrb;
    logic        p_wlast;

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rq_pop) ah <= ah + 1;
        if (dq_pop) dh <= dh + 1;
        if (rst_n) begin
            if (awvalid && awready) begin
                aw_log_a[aw_n[7:0]] <= awaddr;
                aw_log_l[aw_n[7:0]] <= awlen;
                aw_n <= aw_n + 1;
                if (awid || awsize != 3'b011 || awburst != 2'b01 || awlock ||
                    awcache != 4'b0011 || awprot != 3'b000 || awqos != 4'b0000 || awuser)
                    attr_bad <= attr_bad + 1;
            end
            if (wvalid && wready) begin
                w_log_d[w_n[7:0]] <= wdata;
                w_log_s[w_n[7:0]] <= wstrb;
                w_log_l[w_n[7:0]] <= wlast;
                w_n <= w_n + 1;
                if (wuser) attr_bad <= attr_bad + 1;
            end
            if (p_aw_wait && !(awvalid && awaddr == p_awaddr && awlen == p_awlen))
                hold_bad_aw <= hold_bad_aw + 1;
            if (p_w_wait && !(wvalid && wdata == p_wdata && wstrb == p_wstrb && wlast == p_wlast))
                hold_bad_w <= hold_bad_w + 1;
            p_aw_wait <= awvalid && !awready;
            p_w_wait  <= wvalid && !wready;
        end else begin
            p_aw_wait <= 1'b0;
            p_w_wait  <= 1'b0;
        end
        p_awaddr <= awaddr; p_awlen <= awlen;
        p_wdata <= wdata; p_wstrb <= wstrb; p_wlast <= wlast;
    end

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_addr(input logic [31:0] a, input logic [7:0] l);
        aq_addr[at[7:0]] = a; aq_len[at[7:0]] = l; at = at + 1;
    endtask

    task automatic push_data(input logic [7:0] l, input logic [63:0] base);
        for (int i = 0; i <= int'(l); i++) begin
            dq_d[dt[7:0]]    = base + 64'(i);
            dq_s[dt[7:0]]    = 8'(8'h0F << (i % 5)) | 8'h01;
            ex_last[dt[7:0]] = (i == int'(l));
            dt = dt + 1;
        end
    endtask

    task automatic wait_counts(input int naw, input int nw);
        for (int i = 0; i < 5000 && (aw_n < naw || w_n < nw); i++) @(negedge clk);
    endtask

    // Compare logged beats from index lo to hi-1 with the queued beats.
    task automatic check_beats(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            chk(w_log_d[i[7:0]] == dq_d[i[7:0]] && w_log_s[i[7:0]] == dq_s[i[7:0]],
                "R5 beat data/strobe", w_log_d[i[7:0]], dq_d[i[7:0]]);
            chk(w_log_l[i[7:0]] == ex_last[i[7:0]], "R5 last flag position",
                64'(w_log_l[i[7:0]]), 64'(ex_last[i[7:0]]));
        end
    endtask

    task automatic check_addrs(input int lo, input int hi);
        for (int i = lo; i < hi; i++)
            chk(aw_log_a[i[7:0]] == aq_addr[i[7:0]] && aw_log_l[i[7:0]] == aq_len[i[7:0]],
                "R1 address/length", {aw_log_a[i[7:0]], 24'h0, aw_log_l[i[7:0]]},
                {aq_addr[i[7:0]], 24'h0, aq_len[i[7:0]]});
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!awvalid && !wvalid, "R11 valids low after reset", 64'({awvalid, wvalid}), 64'd0);
        chk(!wr_err, "R11 error flag low after reset", 64'(wr_err), 64'd0);
        chk(bready, "R9 response ready high", 64'(bready), 64'd1);
    endtask

    task automatic t_init_gate;
        push_addr(32'h1122_0000, 8'd1);
        push_data(8'd1, 64'h2233_4455_6677_8890);
        repeat (20) @(negedge clk);
        chk(aw_n == 0 && w_n == 0 && !awvalid && !wvalid, "R8 no traffic before init",
            64'(aw_n + w_n), 64'd0);
        chk(ah == 0 && dh == 0, "R8 no pops before init", 64'(ah + dh), 64'd0);
        init_done = 1'b1;
        wait_counts(1, 2);
        repeat (3) @(negedge clk);
        check_addrs(0, 1);
        check_beats(0, 2);
        chk(attr_bad == 0, "R2 constant attributes", 64'(attr_bad), 64'd0);
    endtask

    task automatic t_stalls;
        stall_en = 1'b1;
        push_addr(32'h1234_0000, 8'd0);
        push_addr(32'h5678_0040, 8'd3);
        push_addr(32'h6789_0100, 8'd7);
        push_data(8'd0, 64'h1000);
        push_data(8'd3, 64'h2000);
        push_data(8'd7, 64'h3000);
        wait_counts(4, 15);
        repeat (5) @(negedge clk);
        chk(aw_n == 4 && w_n == 15, "R5 all beats under stalls", 64'(w_n), 64'd15);
        check_addrs(1, 4);
        check_beats(2, 15);
        chk(hold_bad_aw == 0, "R3 address held under stall", 64'(hold_bad_aw), 64'd0);
        chk(hold_bad_w == 0, "R4 data held under stall", 64'(hold_bad_w), 64'd0);
        stall_en = 1'b0;
    endtask

    task automatic t_outstanding;
        for (int i = 0; i < 20; i++) push_addr(32'h8000_0000 + 32'(i * 16), 8'd1);
        repeat (60) @(negedge clk);
        chk(aw_n == 4 + 16, "R6 addresses issued without data", 64'(aw_n), 64'd20);
        chk(!awvalid, "R7 address valid low at 16 outstanding", 64'(awvalid), 64'd0);
        chk(w_n == 15, "R7 no beats without data", 64'(w_n), 64'd15);
        for (int i = 0; i < 20; i++) push_data(8'd1, 64'hA000 + 64'(i * 2));
        wait_counts(24, 55);
        repeat (5) @(negedge clk);
        chk(aw_n == 24, "R7 remaining addresses follow data", 64'(aw_n), 64'd24);
        check_addrs(4, 24);
        check_beats(15, 55);
        chk(hold_bad_aw == 0 && hold_bad_w == 0, "R3 R4 holds", 64'(hold_bad_aw + hold_bad_w), 64'd0);
    endtask

    task automatic send_resp(input logic [1:0] code);
        bresp = code; bvalid = 1'b1;
        @(negedge clk);
        bvalid = 1'b0; bresp = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_resp;
        send_resp(2'b00);
        chk(!wr_err, "R10 OKAY leaves flag clear", 64'(wr_err), 64'd0);
        send_resp(2'b01);
        chk(!wr_err, "R10 EXOKAY leaves flag clear", 64'(wr_err), 64'd0);
        send_resp(2'b10);
        chk(wr_err, "R10 SLVERR sets flag", 64'(wr_err), 64'd1);
        send_resp(2'b00);
        chk(wr_err, "R10 flag sticky after OKAY", 64'(wr_err), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_err, "R10 flag cleared by reset", 64'(wr_err), 64'd0);
        chk(bready, "R9 response ready high after reset", 64'(bready), 64'd1);
        send_resp(2'b11);
        chk(wr_err, "R10 DECERR sets flag", 64'(wr_err), 64'd1);
    endtask

    initial begin
        t_reset();
        t_init_gate();
        t_stalls();
        t_outstanding();
        t_resp();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule